// File: doc/BRIEF.md
# Interrupt Context Stacking Sequencer

This block saves and restores the working state of a small 8-bit processor around an interrupt. When the core accepts an interrupt, the sequencer captures the return program counter, the low byte of the index register, the accumulator and the condition code register. It then writes these five bytes to a byte-wide stack in memory, one per clock. The stack grows downward, and the stack pointer always holds the address of the next free byte.

On a return request the sequencer reads the same five bytes back in the opposite order. It presents them on its restore outputs. From the recovered program counter it then fills a three-byte instruction prefetch buffer, so the core can resume decoding at once. The high byte of the index register is never part of the frame. Vector fetch, arbitration and decode belong to other blocks.

The memory port is registered and assumes a synchronous memory that returns read data in the cycle after the address cycle. The stack pointer is held inside the block. The core can load it through a write strobe while no sequence is running.

Top module: `ctx_stack_seq`

## Requirements
- R1: During and directly after reset, `busy`, `done` and `mem_we` are low and `sp` equals the parameter `SP_INIT`.
- R2: An accepted entry request captures `pc_in`, `ix_lo_in`, `acc_in` and `ccr_in` at the accepting edge. Inputs that change later have no effect. In the five cycles that follow the accepting cycle, one byte is written per cycle to addresses SP, SP-1, SP-2, SP-3, SP-4. SP is the pointer value at acceptance. The bytes go in the order PC[7:0], PC[15:8], index low, accumulator, condition codes.
- R3: When stacking ends, `sp` equals the address of the condition code byte minus one, which is SP-5. All pointer and address arithmetic wraps modulo 2^16.
- R4: A frame consists of exactly five write cycles. No other write cycle occurs, and no index high byte is ever stored.
- R5: An accepted return request reads addresses SP+1 through SP+5, one per cycle, in the five cycles after the accepting cycle. `sp` ends at SP+5.
- R6: The first byte read appears on `ccr_out`, the second on `acc_out` and the third on `ix_lo_out`. The fourth and fifth form `pc_out` as {fourth, fifth}. Read data is taken from `mem_rdata` one cycle after its address cycle.
- R7: After the last pop, the addresses PC, PC+1 and PC+2 (wrapping) are issued in three consecutive cycles. The first of these is the cycle after the PC low byte arrives, seven cycles after acceptance. The byte read from PC+i is held in `pf_buf[8*i+7:8*i]`.
- R8: `done` is high for exactly one cycle. For an entry this is the sixth cycle after acceptance, after the last write. For a return it is the eleventh cycle, after the third prefetch byte arrives. `busy` is high from acceptance until the `done` cycle, and low in the `done` cycle.
- R9: While `busy` is high, `entry_req`, `ret_req` and `sp_wr_en` have no effect on the memory traffic, the restored values or `sp`.
- R10: If `entry_req` and `ret_req` are high in the same idle cycle, the entry is accepted and the return is dropped. An `sp_wr_en` in a cycle that accepts a request is ignored.
- R11: In an idle cycle with no request, `sp_wr_en` loads `sp_wr_data` into `sp`, and `sp` shows the new value in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_req | input | 1 | Start interrupt entry stacking |
| ret_req | input | 1 | Start return-from-interrupt unstacking |
| sp_wr_en | input | 1 | Load the stack pointer while idle |
| sp_wr_data | input | AW (16) | Stack pointer load value |
| pc_in | input | AW (16) | Return program counter to be saved |
| ix_lo_in | input | DW (8) | Index register low byte to be saved |
| acc_in | input | DW (8) | Accumulator to be saved |
| ccr_in | input | DW (8) | Condition code register to be saved |
| mem_addr | output | AW (16) | Memory byte address |
| mem_wdata | output | DW (8) | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW (8) | Memory read data, one cycle after the address |
| pc_out | output | AW (16) | Restored program counter |
| ix_lo_out | output | DW (8) | Restored index low byte |
| acc_out | output | DW (8) | Restored accumulator |
| ccr_out | output | DW (8) | Restored condition codes |
| pf_buf | output | PF_N*DW (24) | Prefetch buffer, byte i at bits [8i+7:8i] |
| sp | output | AW (16) | Current stack pointer |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step counter or state shows up in the very next cycle on the memory port. The bench would see a misplaced write byte, a write address off by one from `sp`, an extra or missing write cycle, or a read address that skips. A stack pointer fault is visible on `sp` and on the next address issued. A misaligned capture of read data only appears at the `done` cycle of a return, as a swapped restored register or a prefetch taken from the wrong address. For that reason every return is followed by a check of all restored values and of all three buffer bytes.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP,
    ST_PCWAIT,
    ST_FETCH,
    ST_FDRAIN
  } seq_st_t;

  // fixed frame: five bytes
  localparam int FRAME_N = 5;

  // read tags, in pop order; prefetch tags follow the frame
  localparam int TG_CCR = 0;
  localparam int TG_ACC = 1;
  localparam int TG_XL  = 2;
  localparam int TG_PCH = 3;
  localparam int TG_PCL = 4;
  localparam int TG_PF0 = 5;
endpackage

// File: rtl/ctx_sp_reg.sv
module ctx_sp_reg #(
  parameter int unsigned AW      = 16,
  parameter int unsigned SP_INIT = 'h01FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= AW'(SP_INIT);
    end else if (ld) begin
      sp_q <= ld_val;
    end else if (dec) begin
      sp_q <= sp_q - AW'(1);
    end else if (inc) begin
      sp_q <= sp_q + AW'(1);
    end
  end
endmodule

// File: rtl/ctx_rd_pipe.sv
module ctx_rd_pipe #(
  parameter int unsigned TW  = 3,
  parameter int unsigned LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_vld,
  input  logic [TW-1:0] iss_tag,
  output logic          cap_vld,
  output logic [TW-1:0] cap_tag
);
  localparam int unsigned NS = LAT + 1;

  logic [NS-1:0] vld_q;
  logic [TW-1:0] tag_q [NS];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int s = 0; s < NS; s++) tag_q[s] <= '0;
    end else begin
      vld_q[0] <= iss_vld;
      tag_q[0] <= iss_tag;
      for (int s = 1; s < NS; s++) begin
        vld_q[s] <= vld_q[s-1];
        tag_q[s] <= tag_q[s-1];
      end
    end
  end

  assign cap_vld = vld_q[NS-1];
  assign cap_tag = tag_q[NS-1];
endmodule

// File: rtl/ctx_pf_buf.sv
module ctx_pf_buf #(
  parameter int unsigned DW   = 8,
  parameter int unsigned N    = 3,
  parameter int unsigned TW   = 3,
  parameter int unsigned BASE = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_tag,
  input  logic [DW-1:0] wr_data,
  output logic [N*DW-1:0] buf_flat
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_byte
      logic [DW-1:0] byte_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          byte_q <= '0;
        end else if (wr_en && (wr_tag == TW'(BASE + i))) begin
          byte_q <= wr_data;
        end
      end
      assign buf_flat[i*DW +: DW] = byte_q;
    end
  endgenerate
endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter int unsigned DW      = 8,
  parameter int unsigned PF_N    = 3,
  parameter int unsigned RD_LAT  = 1,
  parameter int unsigned SP_INIT = 'h01FF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               entry_req,
  input  logic               ret_req,
  input  logic               sp_wr_en,
  input  logic [AW-1:0]      sp_wr_data,
  input  logic [AW-1:0]      pc_in,
  input  logic [DW-1:0]      ix_lo_in,
  input  logic [DW-1:0]      acc_in,
  input  logic [DW-1:0]      ccr_in,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic               mem_we,
  input  logic [DW-1:0]      mem_rdata,
  output logic [AW-1:0]      pc_out,
  output logic [DW-1:0]      ix_lo_out,
  output logic [DW-1:0]      acc_out,
  output logic [DW-1:0]      ccr_out,
  output logic [PF_N*DW-1:0] pf_buf,
  output logic [AW-1:0]      sp,
  output logic               busy,
  output logic               done
);
  localparam int unsigned TAG_W = $clog2(FRAME_N + PF_N);
  localparam int unsigned IDX_W = $clog2(FRAME_N + 1);
  localparam logic [TAG_W-1:0] PF_LAST = TAG_W'(TG_PF0 + PF_N - 1);

  seq_st_t          st;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]    snap_pc;
  logic [DW-1:0]    snap_xl, snap_acc, snap_ccr;
  logic [DW-1:0]    push_byte;

  logic             accept_any;
  logic             sp_ld, sp_inc, sp_dec;
  logic             iss_vld, cap_vld, pcl_hit;
  logic [TAG_W-1:0] iss_tag, cap_tag;
  logic             pf_we;

  // stack pointer
  assign accept_any = (st == ST_IDLE) && (entry_req || ret_req);
  assign sp_ld  = (st == ST_IDLE) && !entry_req && !ret_req && sp_wr_en;
  assign sp_dec = (st == ST_PUSH) && (idx != IDX_W'(FRAME_N));
  assign sp_inc = (st == ST_POP)  && (idx != IDX_W'(FRAME_N));

  ctx_sp_reg #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk    (clk),
    .rst    (rst),
    .ld     (sp_ld),
    .ld_val (sp_wr_data),
    .inc    (sp_inc),
    .dec    (sp_dec),
    .sp_q   (sp)
  );

  // read tag pipeline aligned to memory latency
  assign pcl_hit = cap_vld && (cap_tag == TAG_W'(TG_PCL));

  always_comb begin
    iss_vld = 1'b0;
    iss_tag = '0;
    unique case (st)
      ST_POP: begin
        iss_vld = (idx != IDX_W'(FRAME_N));
        iss_tag = TAG_W'(idx);
      end
      ST_PCWAIT: begin
        iss_vld = pcl_hit;
        iss_tag = TAG_W'(TG_PF0);
      end
      ST_FETCH: begin
        iss_vld = 1'b1;
        iss_tag = TAG_W'(TG_PF0) + TAG_W'(idx);
      end
      default: ;
    endcase
  end

  ctx_rd_pipe #(.TW(TAG_W), .LAT(RD_LAT)) u_pipe (
    .clk     (clk),
    .rst     (rst),
    .iss_vld (iss_vld),
    .iss_tag (iss_tag),
    .cap_vld (cap_vld),
    .cap_tag (cap_tag)
  );

  // push byte selection: low PC first, condition codes last
  always_comb begin
    unique case (idx)
      IDX_W'(0): push_byte = snap_pc[DW-1:0];
      IDX_W'(1): push_byte = snap_pc[2*DW-1:DW];
      IDX_W'(2): push_byte = snap_xl;
      IDX_W'(3): push_byte = snap_acc;
      default:   push_byte = snap_ccr;
    endcase
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      idx       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      snap_pc   <= '0;
      snap_xl   <= '0;
      snap_acc  <= '0;
      snap_ccr  <= '0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          idx <= '0;
          if (entry_req) begin
            st       <= ST_PUSH;
            snap_pc  <= pc_in;
            snap_xl  <= ix_lo_in;
            snap_acc <= acc_in;
            snap_ccr <= ccr_in;
          end else if (ret_req) begin
            st <= ST_POP;
          end
        end
        ST_PUSH: begin
          if (idx == IDX_W'(FRAME_N)) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end else begin
            mem_we    <= 1'b1;
            mem_addr  <= sp;
            mem_wdata <= push_byte;
            idx       <= idx + IDX_W'(1);
          end
        end
        ST_POP: begin
          if (idx == IDX_W'(FRAME_N)) begin
            st <= ST_PCWAIT;
          end else begin
            mem_addr <= sp + AW'(1);
            idx      <= idx + IDX_W'(1);
          end
        end
        ST_PCWAIT: begin
          if (pcl_hit) begin
            mem_addr <= {pc_out[AW-1:DW], mem_rdata};
            idx      <= IDX_W'(1);
            st       <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          mem_addr <= mem_addr + AW'(1);
          idx      <= idx + IDX_W'(1);
          if (idx == IDX_W'(PF_N - 1)) st <= ST_FDRAIN;
        end
        ST_FDRAIN: begin
          if (cap_vld && (cap_tag == PF_LAST)) begin
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // restore registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ccr_out   <= '0;
      acc_out   <= '0;
      ix_lo_out <= '0;
      pc_out    <= '0;
    end else if (cap_vld) begin
      if (cap_tag == TAG_W'(TG_CCR)) ccr_out   <= mem_rdata;
      if (cap_tag == TAG_W'(TG_ACC)) acc_out   <= mem_rdata;
      if (cap_tag == TAG_W'(TG_XL))  ix_lo_out <= mem_rdata;
      if (cap_tag == TAG_W'(TG_PCH)) pc_out[AW-1:DW] <= mem_rdata;
      if (cap_tag == TAG_W'(TG_PCL)) pc_out[DW-1:0]  <= mem_rdata;
    end
  end

  assign pf_we = cap_vld && (cap_tag >= TAG_W'(TG_PF0));

  ctx_pf_buf #(.DW(DW), .N(PF_N), .TW(TAG_W), .BASE(TG_PF0)) u_pf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (pf_we),
    .wr_tag   (cap_tag),
    .wr_data  (mem_rdata),
    .buf_flat (pf_buf)
  );

  assign busy = (st != ST_IDLE);

  logic unused_ok;
  assign unused_ok = accept_any;
endmodule

// File: rtl/ctx_stack_seq_chk.sv
module ctx_stack_seq_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] sp,
  input logic          busy,
  input logic          done
);
  // R2: each write lands one above the already decremented pointer
  assert_wr_addr_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == sp + AW'(1)));

  // R3: the pointer steps down by one between back-to-back writes
  assert_sp_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (sp == $past(sp) - AW'(1)));

  // R4: no write outside a running sequence
  assert_we_in_seq_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R8: done lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: the end of busy coincides with done
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind ctx_stack_seq ctx_stack_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .sp       (sp),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_ctx_stack_seq.sv
module test_ctx_stack_seq;
  localparam int CLK_P = 10;
  localparam logic [15:0] SP_RST = 16'h01FF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic entry_req = 0, ret_req = 0, sp_wr_en = 0;
  logic [15:0] sp_wr_data = '0, pc_in = '0;
  logic [7:0]  ix_lo_in = '0, acc_in = '0, ccr_in = '0;
  logic [15:0] mem_addr, pc_out, sp;
  logic [7:0]  mem_wdata, ix_lo_out, acc_out, ccr_out;
  logic [7:0]  mem_rdata = '0;
  logic        mem_we, busy, done;
  logic [23:0] pf_buf;

  always #(CLK_P/2) clk = ~clk;

  ctx_stack_seq #(.SP_INIT(SP_RST)) i_ctx_stack_seq (
    .clk(clk), .rst(rst), .entry_req(entry_req), .ret_req(ret_req),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .pc_in(pc_in),
    .ix_lo_in(ix_lo_in), .acc_in(acc_in), .ccr_in(ccr_in),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .ix_lo_out(ix_lo_out),
    .acc_out(acc_out), .ccr_out(ccr_out), .pf_buf(pf_buf), .sp(sp),
    .busy(busy), .done(done)
  );

  // sparse memory model, one-cycle read latency
  logic [7:0] mem [int];

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    mem_rdata <= rd(mem_addr);
  end

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0;
  logic [15:0] model_sp = SP_RST;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", rq, what, act, exp, $time);
    end
  endtask

  // per-cycle expectation queue
  typedef struct {
    bit          we;
    bit          ca;
    logic [15:0] addr;
    logic [7:0]  wd;
    bit          dn;
    bit          bz;
    string       rq;
  } exp_t;
  exp_t exq[$];

  function automatic exp_t mk(bit we, bit ca, logic [15:0] a, logic [7:0] wd, bit dn, bit bz, string rq);
    exp_t e;
    e.we = we; e.ca = ca; e.addr = a; e.wd = wd; e.dn = dn; e.bz = bz; e.rq = rq;
    return e;
  endfunction

  always @(posedge clk) begin
    #(CLK_P/4);
    if (chk_on) begin
      exp_t e;
      if (exq.size() > 0) e = exq.pop_front();
      else e = mk(0, 0, '0, '0, 0, 0, "R4 idle");
      chk(e.rq, 32'(mem_we), 32'(e.we), "mem_we");
      chk(e.rq, 32'(done), 32'(e.dn), "done (R8)");
      chk(e.rq, 32'(busy), 32'(e.bz), "busy (R8)");
      if (e.ca) chk(e.rq, 32'(mem_addr), 32'(e.addr), "mem_addr");
      if (e.we) chk(e.rq, 32'(mem_wdata), 32'(e.wd), "mem_wdata");
    end
  end

  task automatic q_entry(input logic [15:0] sp0, input logic [15:0] pc, input logic [7:0] xl, a, cc);
    logic [7:0] b [5];
    b[0] = pc[7:0]; b[1] = pc[15:8]; b[2] = xl; b[3] = a; b[4] = cc;
    exq.push_back(mk(0, 0, '0, '0, 0, 1, "R2 accept"));
    for (int k = 0; k < 5; k++)
      exq.push_back(mk(1, 1, sp0 - 16'(k), b[k], 0, 1, "R2 push"));
    exq.push_back(mk(0, 0, '0, '0, 1, 0, "R8 entry done"));
  endtask

  task automatic q_ret(input logic [15:0] sp0);
    logic [15:0] pc;
    pc = {rd(sp0 + 16'd4), rd(sp0 + 16'd5)};
    exq.push_back(mk(0, 0, '0, '0, 0, 1, "R5 accept"));
    for (int k = 1; k <= 5; k++)
      exq.push_back(mk(0, 1, sp0 + 16'(k), '0, 0, 1, "R5 pop"));
    exq.push_back(mk(0, 0, '0, '0, 0, 1, "R6 wait"));
    for (int k = 0; k < 3; k++)
      exq.push_back(mk(0, 1, pc + 16'(k), '0, 0, 1, "R7 fetch"));
    exq.push_back(mk(0, 0, '0, '0, 0, 1, "R7 drain"));
    exq.push_back(mk(0, 0, '0, '0, 1, 0, "R8 return done"));
  endtask

  task automatic clr_in();
    entry_req = 0; ret_req = 0; sp_wr_en = 0;
  endtask

  task automatic inject_busy();
    entry_req = 1; ret_req = 1; sp_wr_en = 1; sp_wr_data = 16'h4321;
    pc_in = 16'hDEAD; // R9: must not be captured
    @(negedge clk);
    clr_in();
  endtask

  task automatic sp_load(input logic [15:0] v);
    @(negedge clk);
    sp_wr_en = 1; sp_wr_data = v;
    @(negedge clk);
    sp_wr_en = 0;
    model_sp = v;
    chk("R11", 32'(sp), 32'(v), "sp after load");
  endtask

  task automatic run_entry(input logic [15:0] pc, input logic [7:0] xl, a, cc,
                           input bit both, input bit spw, input bit inj);
    logic [15:0] sp0;
    @(negedge clk);
    sp0 = model_sp;
    pc_in = pc; ix_lo_in = xl; acc_in = a; ccr_in = cc;
    entry_req = 1; ret_req = both; sp_wr_en = spw; sp_wr_data = 16'hBEEF;
    q_entry(sp0, pc, xl, a, cc);
    @(negedge clk);
    clr_in();
    pc_in = ~pc; ix_lo_in = ~xl; acc_in = ~a; ccr_in = ~cc; // R2 snapshot
    if (inj) begin
      repeat (2) @(negedge clk);
      inject_busy();
      repeat (3) @(negedge clk);
    end else begin
      repeat (6) @(negedge clk);
    end
    model_sp = sp0 - 16'd5;
    chk("R3", 32'(sp), 32'(model_sp), "sp after stacking");
  endtask

  task automatic run_ret(input bit inj);
    logic [15:0] sp0, pc;
    logic [7:0]  e_cc, e_a, e_x;
    @(negedge clk);
    sp0 = model_sp;
    e_cc = rd(sp0 + 16'd1); e_a = rd(sp0 + 16'd2); e_x = rd(sp0 + 16'd3);
    pc = {rd(sp0 + 16'd4), rd(sp0 + 16'd5)};
    ret_req = 1;
    q_ret(sp0);
    @(negedge clk);
    clr_in();
    if (inj) begin
      repeat (2) @(negedge clk);
      inject_busy();
      repeat (8) @(negedge clk);
    end else begin
      repeat (11) @(negedge clk);
    end
    model_sp = sp0 + 16'd5;
    chk("R5", 32'(sp), 32'(model_sp), "sp after unstacking");
    chk("R6", 32'(ccr_out), 32'(e_cc), "ccr_out");
    chk("R6", 32'(acc_out), 32'(e_a), "acc_out");
    chk("R6", 32'(ix_lo_out), 32'(e_x), "ix_lo_out");
    chk("R6", 32'(pc_out), 32'(pc), "pc_out");
    for (int i = 0; i < 3; i++)
      chk("R7", 32'(pf_buf[8*i +: 8]), 32'(rd(pc + 16'(i))), "prefetch byte");
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: values while reset is held
    #1;
    chk("R1", 32'(busy), 0, "busy in reset");
    chk("R1", 32'(mem_we), 0, "mem_we in reset");
    @(negedge clk);
    rst = 0;
    chk_on = 1;
    @(negedge clk);
    chk("R1", 32'(sp), 32'(SP_RST), "sp after reset");
    chk("R1", 32'(done), 0, "done after reset");

    // basic round trip
    sp_load(16'h0140);
    run_entry(16'h1234, 8'h56, 8'h78, 8'h9A, 0, 0, 0);
    run_ret(0);

    // R3 / R7 wrap-around of pointer and prefetch address
    sp_load(16'h0002);
    run_entry(16'hFFFE, 8'h11, 8'h22, 8'h33, 0, 0, 0);
    run_ret(0);

    // nested frames, second with busy-time requests (R9)
    sp_load(16'h0300);
    run_entry(16'hA001, 8'hC1, 8'hC2, 8'hC3, 0, 0, 0);
    run_entry(16'hB002, 8'hD1, 8'hD2, 8'hD3, 0, 0, 1);
    run_ret(0);
    run_ret(1);

    // R10: entry beats return, load ignored on accept
    run_entry(16'h5A5A, 8'h01, 8'h02, 8'h03, 1, 1, 0);
    run_ret(0);

    // return from a hand-built frame
    sp_load(16'h0800);
    mem[int'(16'h0801)] = 8'hE7;
    mem[int'(16'h0802)] = 8'h3C;
    mem[int'(16'h0803)] = 8'h81;
    mem[int'(16'h0804)] = 8'h40;
    mem[int'(16'h0805)] = 8'hFF;
    run_ret(0);

    repeat (4) @(negedge clk);
    report();
  end
endmodule